// File: doc/BRIEF.md
# Modem Interrupt and Control Register Set

This block is the register set a host processor uses to supervise a wireless modem data pump. It has four byte-wide registers: control, interrupt mask, interrupt flags and receive status. The receive and transmit halves of the modem report through single-cycle event pulses. Each pulse sets a flag, and for the receive side it also sets a status bit. Flags that are enabled in the mask pull the shared active-low interrupt line low. The host can either service that interrupt or leave the mask at zero and poll the flag register.

Two action bits in the control register start up the two halves of the modem. The receive start-up clears only the receive flags and the receive status, and leaves every other register alone. The transmit start-up raises the transmit-empty flag, so the host is asked for the first block straight away. Reading the flag register acknowledges every flag except transmit-empty. That flag stays set until the transmitter commits a new block. One further control bit is sent to the transmitter as the continuation indication.

The bus is synchronous. `host_rdata` shows the register selected by `host_addr` in the same cycle, and a read takes effect on the clock edge that ends the cycle. Register map: 0 is control, 1 is mask, 2 is flags (writes ignored), 3 is status (writes ignored).

Top module: `modem_irq_regs`

## Requirements
- R1: After reset, all four registers read as 0x00 and `irq_n` is high.
- R2: `irq_n` is low exactly when some flag bit and the same mask bit are both 1. With the mask at zero, the flags can still be read at address 2.
- R3: A pulse on `rx_sync_pulse`, `rx_dec_pulse` or `rx_idle_pulse` sets flag bit 0, 1 or 2 respectively, and sets the status bit at the same position. Status bits stay set until a receive start-up.
- R4: A read of address 2 returns the flags and then clears flag bits 0 to 2, keeping bit 4. An event pulse in the same cycle as the read is not lost.
- R5: Writing control with bit 5 = 1 clears flag bits 0 to 2 and the whole status register. The mask, control bit 3 and flag bit 4 are unchanged. The clear wins over a receive event in the same cycle.
- R6: Writing control with bit 4 = 1 sets flag bit 4 (transmit empty). The interrupt is asserted on the next cycle if mask bit 4 is 1.
- R7: A `tx_commit` pulse clears flag bit 4. A transmit start-up or `tx_empty_pulse` in the same cycle wins and leaves the flag set.
- R8: Control bit 3 drives `tx_cont`. Control bits 5 and 4 are actions and read back as 0. The other control bits read back as written.
- R9: `rx_err_pulse` sets status bit 3 and increments the 4-bit count in status bits 7:4. The count saturates at 15.
- R10: The mask register at address 1 reads back as written. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| rx_sync_pulse | input | 1 | Receiver found sync |
| rx_dec_pulse | input | 1 | Receiver decoded a block |
| rx_idle_pulse | input | 1 | Receiver saw an idle channel |
| rx_err_pulse | input | 1 | Receiver sync error |
| tx_empty_pulse | input | 1 | Transmit output buffer became empty |
| tx_commit | input | 1 | Transmitter took a new block |
| tx_cont | output | 1 | Continuation indication to transmitter |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets cycles where two actions land together: a flag read colliding with a new event, a receive start-up colliding with a sync pulse, and a commit colliding with a transmit-empty set. A design with the wrong priority would drop an event, or leave a stale flag, in exactly those cycles. The bench drives the error count past 15 to catch a count that wraps back to a small value. It checks that a receive start-up leaves the mask, the continuation bit and the transmit-empty flag untouched, which catches a start-up that clears too much. Random traffic with a fixed seed also probes the ignored writes to the flag and status addresses.

// File: rtl/modem_irq_pkg.sv
package modem_irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int CTL_RX_INIT = 5;
  localparam int CTL_TX_INIT = 4;
  localparam int CTL_CONT    = 3;

  // flag / status bit positions
  localparam int EV_SYNC = 0;
  localparam int EV_DEC  = 1;
  localparam int EV_IDLE = 2;
  localparam int ST_ERR  = 3;
  localparam int FL_TXE  = 4;

  localparam int RX_EV_N = 3;
endpackage

// File: rtl/modem_ctrl_mask.sv
module modem_ctrl_mask
  import modem_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_i,
  input  logic         wr_ctrl,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] mask_q
);
  localparam logic [W-1:0] ACT_BITS = W'((1 << CTL_RX_INIT) | (1 << CTL_TX_INIT));

  logic [W-1:0] ctrl_d, mask_d;

  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    if (wr_ctrl) ctrl_d = wdata & ~ACT_BITS;
    if (wr_mask) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/modem_flag_unit.sv
module modem_flag_unit
  import modem_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic               clk,
  input  logic               rst_i,
  input  logic               rd_ack,
  input  logic               rx_init,
  input  logic [RX_EV_N-1:0] rx_ev,
  input  logic               tx_set,
  input  logic               tx_clr,
  output logic [W-1:0]       flags_q
);
  logic [W-1:0] flags_d;
  logic         upd;

  always_comb begin
    flags_d = flags_q;
    if (rd_ack) begin
      for (int i = 0; i < RX_EV_N; i++) flags_d[i] = 1'b0;
    end
    for (int i = 0; i < RX_EV_N; i++) begin
      if (rx_ev[i]) flags_d[i] = 1'b1;
    end
    if (rx_init) begin
      for (int i = 0; i < RX_EV_N; i++) flags_d[i] = 1'b0;
    end
    if (tx_clr) flags_d[FL_TXE] = 1'b0;
    if (tx_set) flags_d[FL_TXE] = 1'b1;
    upd = rd_ack | rx_init | (|rx_ev) | tx_set | tx_clr;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end
endmodule

// File: rtl/modem_rx_status.sv
module modem_rx_status
  import modem_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic               clk,
  input  logic               rst_i,
  input  logic               rx_init,
  input  logic [RX_EV_N-1:0] rx_ev,
  input  logic               rx_err,
  output logic [W-1:0]       status_q
);
  localparam int CNT_W = W - (ST_ERR + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [RX_EV_N-1:0] bits_q, bits_d;
  logic               err_q, err_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               upd;

  always_comb begin
    bits_d = bits_q | rx_ev;
    err_d  = err_q | rx_err;
    cnt_d  = cnt_q;
    if (rx_err && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    if (rx_init) begin
      bits_d = '0;
      err_d  = 1'b0;
      cnt_d  = '0;
    end
    upd = rx_init | rx_err | (|rx_ev);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      bits_q <= '0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      bits_q <= bits_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
    end
  end

  assign status_q = {cnt_q, err_q, bits_q};
endmodule

// File: rtl/modem_irq_regs.sv
module modem_irq_regs
  import modem_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             rx_sync_pulse,
  input  logic             rx_dec_pulse,
  input  logic             rx_idle_pulse,
  input  logic             rx_err_pulse,
  input  logic             tx_empty_pulse,
  input  logic             tx_commit,
  output logic             tx_cont,
  output logic             irq_n
);
  logic [1:0]         rst_sync_q;
  logic               rst_i;
  logic               wr_ctrl, wr_mask, rd_ack, rx_init, tx_init;
  logic [RX_EV_N-1:0] rx_ev;
  logic [REG_W-1:0]   ctrl_q, mask_q, flags_q, status_q;
  reg_sel_e           sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_comb begin
    sel     = reg_sel_e'(host_addr);
    wr_ctrl = host_wr && sel == SEL_CTRL;
    wr_mask = host_wr && sel == SEL_MASK;
    rd_ack  = host_rd && sel == SEL_FLAG;
    rx_init = wr_ctrl && host_wdata[CTL_RX_INIT];
    tx_init = wr_ctrl && host_wdata[CTL_TX_INIT];
    rx_ev   = {rx_idle_pulse, rx_dec_pulse, rx_sync_pulse};
  end

  modem_ctrl_mask #(.W(REG_W)) u_ctrl (
    .clk(clk), .rst_i(rst_i), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
    .wdata(host_wdata), .ctrl_q(ctrl_q), .mask_q(mask_q)
  );

  modem_flag_unit #(.W(REG_W)) u_flags (
    .clk(clk), .rst_i(rst_i), .rd_ack(rd_ack), .rx_init(rx_init),
    .rx_ev(rx_ev), .tx_set(tx_init | tx_empty_pulse), .tx_clr(tx_commit),
    .flags_q(flags_q)
  );

  modem_rx_status #(.W(REG_W)) u_stat (
    .clk(clk), .rst_i(rst_i), .rx_init(rx_init), .rx_ev(rx_ev),
    .rx_err(rx_err_pulse), .status_q(status_q)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: host_rdata = ctrl_q;
      SEL_MASK: host_rdata = mask_q;
      SEL_FLAG: host_rdata = flags_q;
      SEL_STAT: host_rdata = status_q;
    endcase
  end

  assign tx_cont = ctrl_q[CTL_CONT];
  assign irq_n   = ~|(flags_q & mask_q);
endmodule

// File: rtl/modem_irq_regs_chk.sv
module modem_irq_regs_chk
  import modem_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_i,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_addr,
  input logic [REG_W-1:0] host_wdata,
  input logic             rx_sync_pulse,
  input logic             rx_dec_pulse,
  input logic             rx_idle_pulse,
  input logic             tx_empty_pulse,
  input logic             tx_commit,
  input logic [REG_W-1:0] flags,
  input logic [REG_W-1:0] status,
  input logic             tx_cont,
  input logic             irq_n
);
  logic ctl_wr, rxi, txi, any_rx;
  assign ctl_wr = host_wr && host_addr == 2'd0;
  assign rxi    = ctl_wr && host_wdata[CTL_RX_INIT];
  assign txi    = ctl_wr && host_wdata[CTL_TX_INIT];
  assign any_rx = rx_sync_pulse | rx_dec_pulse | rx_idle_pulse;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_i |-> (irq_n && flags == '0 && status == '0)); // R1
  AST_SYNC_SETS: assert property (@(posedge clk) disable iff (!rst_i)
    (rx_sync_pulse && !rxi) |=> (flags[EV_SYNC] && status[EV_SYNC])); // R3
  AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_i)
    (host_rd && host_addr == 2'd2 && !any_rx) |=> (flags[2:0] == 3'b000)); // R4
  AST_RXINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    rxi |=> (status == '0 && flags[2:0] == 3'b000)); // R5
  AST_TXE_ON_INIT: assert property (@(posedge clk) disable iff (!rst_i)
    txi |=> flags[FL_TXE]); // R6
  AST_TXE_COMMIT: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_commit && !txi && !tx_empty_pulse) |=> !flags[FL_TXE]); // R7
  AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !ctl_wr |=> $stable(tx_cont)); // R8
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_i)
    (status[7:4] == 4'hF && !rxi) |=> status[7:4] == 4'hF); // R9
endmodule

bind modem_irq_regs modem_irq_regs_chk u_chk (
  .clk(clk), .rst_i(rst_i), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata),
  .rx_sync_pulse(rx_sync_pulse), .rx_dec_pulse(rx_dec_pulse),
  .rx_idle_pulse(rx_idle_pulse), .tx_empty_pulse(tx_empty_pulse),
  .tx_commit(tx_commit), .flags(flags_q), .status(status_q),
  .tx_cont(tx_cont), .irq_n(irq_n)
);

// File: tb/modem_irq_regs_test.sv
module modem_irq_regs_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       rx_sync_pulse = 0, rx_dec_pulse = 0, rx_idle_pulse = 0, rx_err_pulse = 0;
  logic       tx_empty_pulse = 0, tx_commit = 0;
  logic       tx_cont, irq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_ctrl = 0, m_mask = 0, m_flags = 0, m_stat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_sync_pulse(rx_sync_pulse), .rx_dec_pulse(rx_dec_pulse),
    .rx_idle_pulse(rx_idle_pulse), .rx_err_pulse(rx_err_pulse),
    .tx_empty_pulse(tx_empty_pulse), .tx_commit(tx_commit),
    .tx_cont(tx_cont), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_mask;
      2'd2: return m_flags;
      default: return m_stat;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R8";
      2'd1: return "R10";
      2'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  // ev: 0 sync, 1 dec, 2 idle, 3 err, 4 tx_empty, 5 commit
  task automatic model_update(input bit wr, input bit rd, input logic [1:0] a,
                              input logic [7:0] wd, input logic [5:0] ev);
    bit rxi, txi;
    logic [3:0] cnt;
    rxi = wr && a == 0 && wd[5];
    txi = wr && a == 0 && wd[4];
    if (rd && a == 2) m_flags = m_flags & 8'h10;
    m_flags[2:0] = m_flags[2:0] | ev[2:0];
    if (rxi) m_flags[2:0] = 3'b000;
    if (ev[5]) m_flags[4] = 1'b0;
    if (txi || ev[4]) m_flags[4] = 1'b1;
    m_stat[2:0] = m_stat[2:0] | ev[2:0];
    if (ev[3]) begin
      m_stat[3] = 1'b1;
      cnt = m_stat[7:4];
      if (cnt != 4'hF) cnt = cnt + 4'd1;
      m_stat[7:4] = cnt;
    end
    if (rxi) m_stat = 8'h00;
    if (wr && a == 0) m_ctrl = wd & 8'hCF;
    if (wr && a == 1) m_mask = wd;
  endtask

  task automatic step(input bit wr, input bit rd, input logic [1:0] a,
                      input logic [7:0] wd, input logic [5:0] ev);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
    {tx_commit, tx_empty_pulse, rx_err_pulse, rx_idle_pulse, rx_dec_pulse, rx_sync_pulse} = ev;
    #1;
    check(irq_n == ~|(m_flags & m_mask), "R2", {7'd0, irq_n}, {7'd0, ~|(m_flags & m_mask)});
    check(tx_cont == m_ctrl[3], "R8", {7'd0, tx_cont}, {7'd0, m_ctrl[3]});
    if (rd) check(host_rdata == model_read(a), tag_of(a), host_rdata, model_read(a));
    model_update(wr, rd, a, wd, ev);
    @(posedge clk);
    #1;
    host_wr = 0; host_rd = 0;
    {tx_commit, tx_empty_pulse, rx_err_pulse, rx_idle_pulse, rx_dec_pulse, rx_sync_pulse} = '0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    host_addr = a;
    #1;
    check(host_rdata == exp, req, host_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int a = 0; a < 4; a++) peek(2'(a), 8'h00, "R1");
    check(irq_n == 1'b1, "R1", {7'd0, irq_n}, 8'h01);

    // R6: transmit start-up raises txe and interrupt
    step(1, 0, 1, 8'h10, 0);
    step(1, 0, 0, 8'h10, 0);
    peek(2, 8'h10, "R6");
    check(irq_n == 1'b0, "R6", {7'd0, irq_n}, 8'h00);
    // R4: read does not clear txe
    step(0, 1, 2, 0, 0);
    peek(2, 8'h10, "R4");
    // R7: commit with simultaneous empty keeps flag; commit alone clears
    step(0, 0, 0, 0, 6'b110000);
    peek(2, 8'h10, "R7");
    step(0, 0, 0, 0, 6'b100000);
    peek(2, 8'h00, "R7");
    check(irq_n == 1'b1, "R7", {7'd0, irq_n}, 8'h01);
    // R8: action bits read as zero, bit 3 drives tx_cont
    step(1, 0, 0, 8'hFF, 0);
    peek(0, 8'hCF, "R8");
    check(tx_cont == 1'b1, "R8", {7'd0, tx_cont}, 8'h01);
    // R4: event colliding with read survives
    step(0, 0, 0, 0, 6'b000011);
    step(0, 1, 2, 0, 6'b000100);
    peek(2, 8'h14, "R4");
    // R2: mask clear, flags still visible, no interrupt
    step(1, 0, 1, 8'h00, 0);
    peek(2, 8'h14, "R2");
    check(irq_n == 1'b1, "R2", {7'd0, irq_n}, 8'h01);
    // R9: saturation
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 6'b001000);
    peek(3, 8'hFF, "R9");
    // R10: writes to flag and status ignored
    step(1, 0, 2, 8'hFF, 0);
    step(1, 0, 3, 8'h00, 0);
    peek(3, 8'hFF, "R10");
    peek(2, 8'h14, "R10");
    // R5: receive start-up colliding with sync, others preserved
    step(1, 0, 1, 8'h17, 0);
    step(1, 0, 0, 8'h28, 6'b000001);
    peek(2, 8'h10, "R5");
    peek(3, 8'h00, "R5");
    peek(1, 8'h17, "R5");
    check(tx_cont == 1'b1, "R5", {7'd0, tx_cont}, 8'h01);
    // R3: events set flags and status
    step(0, 0, 0, 0, 6'b000110);
    peek(3, 8'h06, "R3");

    // constrained random traffic
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] wd;
      logic [5:0] ev;
      bit wr, rd;
      wr = ($urandom % 4) == 0;
      rd = ($urandom % 3) == 0;
      wd = 8'($urandom);
      if (($urandom % 8) != 0) wd[5] = 1'b0;
      if (($urandom % 4) != 0) wd[4] = 1'b0;
      for (int k = 0; k < 6; k++) ev[k] = ($urandom % 5) == 0;
      step(wr, rd, 2'($urandom), wd, ev);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule